// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock with Alarm

This block is a memory-mapped real-time clock. A one-cycle reference enable arrives at the nominal 32.768 kHz rate. A prescaler with a programmable divide value counts these enables and produces a one-second tick. A trim value shortens one second in every 1024 seconds, which corrects a reference that runs slow. Each tick advances a 32-bit seconds counter. A 32-bit alarm value is compared with that counter.

Software reads and writes four word registers through a simple synchronous port. Writes take effect on the clock edge. Read data is combinational from the address. A status register holds two event flags, which software clears by writing a one to them, and two interrupt enables, which take the written value directly. Two separate interrupt lines leave the block, one for the tick and one for the alarm.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset, the alarm and seconds registers read 0, the divider/trim register reads 0x00007FFF, the status register reads 0, and both interrupt outputs are low.
- R2: The byte offsets are 0x00 for the alarm value, 0x04 for the seconds counter, 0x08 for the divider/trim register and 0x10 for status. In the divider/trim register, bits 15:0 hold the divide value and bits 25:16 hold the trim. Bits 31:26 are ignored on write and read as zero.
- R3: The seconds counter advances once every (divide value + 1) cycles in which ref_en is high. Cycles with ref_en low do not advance it.
- R4: The 1024th second after a counter write, and every 1024th second after that, lasts (divide value + 1 - trim) reference enables. If trim exceeds the divide value, that second lasts one enable. A trim of 0 makes no correction.
- R5: A write to the seconds counter loads the written value and restarts the prescaler and the trim phase. The next increment comes one full second of enables after the write.
- R6: Status bit 1, the tick flag, is set by every one-second tick.
- R7: Status bit 0, the alarm flag, is set one cycle after the seconds counter becomes equal to the alarm value, whether by a tick or by a write. It is not set again while the two values stay equal.
- R8: A write of one to status bit 0 or bit 1 clears that flag. A write of zero leaves it unchanged. An event in the same cycle as a clear wins, and the flag stays set.
- R9: Status bits 3 (tick enable) and 2 (alarm enable) take the written value on every status write.
- R10: irq_tick is high exactly when the tick flag and the tick enable are both set. irq_alarm is high exactly when the alarm flag and the alarm enable are both set. Each stays high until its flag is cleared or its enable is removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | Reference clock enable, one cycle per reference period |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_tick | output | 1 | One-second interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
On every cycle, the assertions check these rules:
- The seconds counter moves only by one or by a write.
- The tick flag rises only on a prescaler tick.
- The alarm flag rises only after a cycle in which the counter equalled the alarm value.
- An event flag survives every cycle that carries no one-write to it.
- The enables change only through status writes.
- A counter write restarts the prescaler.

The exact length of a second, the shortened trim second, and the timing of the restart can only be shown by the bench's scenarios. The same holds for register readback and masking, and for the interrupt outputs seen at the ports.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 5;
    localparam int DIV_W   = 16;
    localparam int TRIM_W  = 10;
    localparam int TRIM_LSB = 16;

    localparam logic [ADDR_W-1:0] OFS_ALARM   = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_COUNT   = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_TRIMDIV = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 5'h10;

    // bit 3 down to bit 0 of the status word
    typedef struct packed {
        logic tick_en;
        logic alarm_en;
        logic tick_flag;
        logic alarm_flag;
    } stat_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ALARM,
        SEL_COUNT,
        SEL_TRIMDIV,
        SEL_STATUS
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_ALARM:   return SEL_ALARM;
            OFS_COUNT:   return SEL_COUNT;
            OFS_TRIMDIV: return SEL_TRIMDIV;
            OFS_STATUS:  return SEL_STATUS;
            default:     return SEL_NONE;
        endcase
    endfunction

    // terminal count for the current second, trimmed seconds clamp at zero
    function automatic logic [DIV_W-1:0] second_limit(
        input logic [DIV_W-1:0]  div,
        input logic [TRIM_W-1:0] trim,
        input logic              short_sec
    );
        logic [DIV_W-1:0] t;
        t = DIV_W'(trim);
        if (!short_sec)
            return div;
        else if (t >= div)
            return '0;
        else
            return div - t;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_sec_pkg::*;
#(
    parameter int TRIM_PERIOD = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_en,
    input  logic              restart,
    input  logic [DIV_W-1:0]  div,
    input  logic [TRIM_W-1:0] trim,
    output logic              tick,
    output logic [DIV_W-1:0]  cnt
);
    localparam int PH_W = (TRIM_PERIOD > 1) ? $clog2(TRIM_PERIOD) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(TRIM_PERIOD - 1);

    logic [DIV_W-1:0] cnt_q;
    logic [PH_W-1:0]  phase_q;
    logic [DIV_W-1:0] limit;
    logic             at_end;

    assign limit  = second_limit(div, trim, phase_q == PH_LAST);
    assign at_end = (cnt_q >= limit);
    assign tick   = ref_en && !restart && at_end;
    assign cnt    = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q   <= '0;
            phase_q <= '0;
        end else if (ref_en) begin
            if (at_end) begin
                cnt_q   <= '0;
                phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtc_status.sv
module rtc_status
    import rtc_sec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [3:0] wbits,
    input  logic       tick,
    input  logic       match,
    output stat_t      stat
);
    stat_t stat_q;
    stat_t wr_view;
    logic  match_q;
    logic  alarm_evt;

    assign wr_view   = stat_t'(wbits);
    assign alarm_evt = match && !match_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q  <= '0;
            match_q <= 1'b1;
        end else begin
            match_q <= match;
            if (wr) begin
                stat_q.tick_en  <= wr_view.tick_en;
                stat_q.alarm_en <= wr_view.alarm_en;
            end
            if (tick)
                stat_q.tick_flag <= 1'b1;
            else if (wr && wr_view.tick_flag)
                stat_q.tick_flag <= 1'b0;
            if (alarm_evt)
                stat_q.alarm_flag <= 1'b1;
            else if (wr && wr_view.alarm_flag)
                stat_q.alarm_flag <= 1'b0;
        end
    end

    assign stat = stat_q;
endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm
    import rtc_sec_pkg::*;
#(
    parameter int               TRIM_PERIOD = 1024,
    parameter logic [DIV_W-1:0] RESET_DIV   = 16'd32767
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_tick,
    output logic              irq_alarm
);
    reg_sel_e          sel;
    logic [DATA_W-1:0] sec_q;
    logic [DATA_W-1:0] alarm_q;
    logic [DIV_W-1:0]  div_q;
    logic [TRIM_W-1:0] trim_q;
    logic              tick;
    logic [DIV_W-1:0]  presc_cnt;
    logic              wr_count;
    logic              wr_status;
    stat_t             stat;

    assign sel       = decode_addr(bus_addr);
    assign wr_count  = bus_wr && (sel == SEL_COUNT);
    assign wr_status = bus_wr && (sel == SEL_STATUS);

    rtc_prescaler #(.TRIM_PERIOD(TRIM_PERIOD)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .ref_en  (ref_en),
        .restart (wr_count),
        .div     (div_q),
        .trim    (trim_q),
        .tick    (tick),
        .cnt     (presc_cnt)
    );

    rtc_status u_stat (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr_status),
        .wbits (bus_wdata[3:0]),
        .tick  (tick),
        .match (sec_q == alarm_q),
        .stat  (stat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_q   <= '0;
            alarm_q <= '0;
            div_q   <= RESET_DIV;
            trim_q  <= '0;
        end else begin
            if (wr_count)
                sec_q <= bus_wdata;
            else if (tick)
                sec_q <= sec_q + 1'b1;
            if (bus_wr && sel == SEL_ALARM)
                alarm_q <= bus_wdata;
            if (bus_wr && sel == SEL_TRIMDIV) begin
                div_q  <= bus_wdata[DIV_W-1:0];
                trim_q <= bus_wdata[TRIM_LSB +: TRIM_W];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_ALARM:   bus_rdata = alarm_q;
            SEL_COUNT:   bus_rdata = sec_q;
            SEL_TRIMDIV: begin
                bus_rdata[DIV_W-1:0]           = div_q;
                bus_rdata[TRIM_LSB +: TRIM_W]  = trim_q;
            end
            SEL_STATUS:  bus_rdata[3:0] = stat;
            default:     bus_rdata = '0;
        endcase
    end

    assign irq_tick  = stat.tick_flag  && stat.tick_en;
    assign irq_alarm = stat.alarm_flag && stat.alarm_en;
endmodule

// File: rtl/rtc_sec_alarm_chk.sv
module rtc_sec_alarm_chk
    import rtc_sec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] sec_q,
    input logic [DATA_W-1:0] alarm_q,
    input logic [DIV_W-1:0]  presc_cnt,
    input logic              tick,
    input stat_t             stat
);
    logic wr_cnt;
    logic wr_st;
    assign wr_cnt = bus_wr && bus_addr == OFS_COUNT;
    assign wr_st  = bus_wr && bus_addr == OFS_STATUS;

    // R3: counter only steps by one unless written
    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_cnt |=> (sec_q == $past(sec_q) || sec_q == $past(sec_q) + 1'b1));

    // R5: a counter write restarts the prescaler
    assert_restart_R5: assert property (@(posedge clk) disable iff (rst)
        wr_cnt |=> presc_cnt == '0);

    // R6: tick flag rises only on a tick
    assert_tick_flag_src_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(stat.tick_flag) |-> $past(tick));

    // R7: alarm flag rises only after an equal cycle
    assert_alarm_src_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(stat.alarm_flag) |-> $past(sec_q == alarm_q));

    // R8: flags survive cycles with no one-write to them
    assert_tick_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (stat.tick_flag && !(wr_st && bus_wdata[1])) |=> stat.tick_flag);
    assert_alarm_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (stat.alarm_flag && !(wr_st && bus_wdata[0])) |=> stat.alarm_flag);

    // R9: enables change only through status writes
    assert_en_stable_R9: assert property (@(posedge clk) disable iff (rst)
        !wr_st |=> $stable({stat.tick_en, stat.alarm_en}));
endmodule

bind rtc_sec_alarm rtc_sec_alarm_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sec_q     (sec_q),
    .alarm_q   (alarm_q),
    .presc_cnt (presc_cnt),
    .tick      (tick),
    .stat      (stat)
);

// File: tb/rtc_sec_alarm_tb.sv
module rtc_sec_alarm_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ref_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_tick;
    logic        irq_alarm;

    int checks = 0;
    int failures = 0;

    localparam logic [4:0] A_AL = 5'h00, A_CN = 5'h04, A_TD = 5'h08, A_ST = 5'h10;

    // {addr, write data, expected readback}
    localparam int NV = 7;
    localparam logic [68:0] VECS [0:NV-1] = '{
        {A_AL, 32'hDEADBEEF, 32'hDEADBEEF},
        {A_CN, 32'h00000100, 32'h00000100},
        {A_TD, 32'h03FF0005, 32'h03FF0005},
        {A_TD, 32'hFFFF0003, 32'h03FF0003},
        {A_ST, 32'h0000000F, 32'h0000000C},
        {A_ST, 32'h00000000, 32'h00000000},
        {A_AL, 32'h00000000, 32'h00000000}
    };

    always #5 clk = ~clk;

    rtc_sec_alarm dut_i (
        .clk(clk), .rst(rst), .ref_en(ref_en),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_tick(irq_tick), .irq_alarm(irq_alarm)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [4:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        rd("R1 alarm", A_AL, 32'h0);
        rd("R1 count", A_CN, 32'h0);
        rd("R1 trimdiv", A_TD, 32'h00007FFF);
        rd("R1 status", A_ST, 32'h0);
        chk("R1 irqs", {30'd0, irq_tick, irq_alarm}, 32'h0);

        // R2 register map walk (R9 enables written, flags not set by writes)
        for (int v = 0; v < NV; v++) begin
            wr(VECS[v][68:64], VECS[v][63:32]);
            rd("R2 readback", VECS[v][68:64], VECS[v][31:0]);
        end

        // R3 divide ratio: div=3 gives 4 enables per second
        wr(A_TD, 32'h00000003);
        ref_en = 1'b1;
        wr(A_CN, 32'd5);
        cyc(3); rd("R5 no early tick", A_CN, 32'd5);
        cyc(1); rd("R3 first second", A_CN, 32'd6);
        cyc(4); rd("R3 second second", A_CN, 32'd7);
        ref_en = 1'b0;
        cyc(20); rd("R3 no advance without ref_en", A_CN, 32'd7);
        rd("R6 tick flag", A_ST, 32'h2);
        chk("R10 tick irq masked", {31'd0, irq_tick}, 32'd0);

        // R9/R10/R8 enable and clear
        wr(A_ST, 32'h8);
        rd("R9 enable set", A_ST, 32'hA);
        chk("R10 tick irq", {31'd0, irq_tick}, 32'd1);
        wr(A_ST, 32'h8);
        rd("R8 zero write keeps flag", A_ST, 32'hA);
        chk("R10 irq held", {31'd0, irq_tick}, 32'd1);
        wr(A_ST, 32'hA);
        rd("R8 one write clears", A_ST, 32'h8);
        chk("R10 irq drops", {31'd0, irq_tick}, 32'd0);
        wr(A_ST, 32'h0);

        // R5 restart on counter write mid-second
        ref_en = 1'b1;
        wr(A_CN, 32'd10);
        cyc(2);
        wr(A_CN, 32'd20);
        cyc(3); rd("R5 restart holds", A_CN, 32'd20);
        cyc(1); rd("R5 full second after write", A_CN, 32'd21);
        ref_en = 1'b0;
        wr(A_ST, 32'h3);

        // R7 alarm through a tick
        wr(A_ST, 32'h4);
        wr(A_AL, 32'h100);
        ref_en = 1'b1;
        wr(A_CN, 32'hFF);
        cyc(5);
        ref_en = 1'b0;
        rd("R7 counter at alarm", A_CN, 32'h100);
        rd("R7 alarm and tick flags", A_ST, 32'h7);
        chk("R10 alarm irq", {30'd0, irq_tick, irq_alarm}, 32'h1);
        wr(A_ST, 32'h5);
        rd("R8 alarm cleared", A_ST, 32'h6);
        chk("R10 alarm irq drops", {31'd0, irq_alarm}, 32'd0);
        cyc(5);
        rd("R7 no re-set while equal", A_ST, 32'h6);

        // R7 alarm through a counter write
        wr(A_AL, 32'h55);
        wr(A_CN, 32'h55);
        cyc(2);
        rd("R7 alarm by write", A_ST, 32'h7);
        wr(A_ST, 32'h3);
        rd("R8 both cleared", A_ST, 32'h0);

        // R4 trim: div=3 trim=2, 1024th second lasts 2 enables
        wr(A_TD, 32'h00020003);
        ref_en = 1'b1;
        wr(A_CN, 32'd0);
        cyc(4093); rd("R4 before short second ends", A_CN, 32'd1023);
        cyc(1);    rd("R4 short second", A_CN, 32'd1024);
        cyc(3);    rd("R4 normal again hold", A_CN, 32'd1024);
        cyc(1);    rd("R4 normal again", A_CN, 32'd1025);
        ref_en = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule